// File: doc/BRIEF.md
# Banked Register File Address Translator

This block sits between a small CPU core and its register file. The register file holds up to sixteen banks of 256 registers each. An 8-bit pointer register controls how short operand addresses reach that storage. Its high nibble names a working-register group, and its low nibble names an expanded bank. Any 8-bit direct address below 10h is redirected into that expanded bank, so the same sixteen short addresses can reach I/O port registers in bank 0 or counter/timer registers in bank Dh. Every other direct address stays in bank 0. A 4-bit working-register number is first widened with the group nibble, and the result is then resolved like a direct address.

A dedicated transfer moves one byte between a linear location and a current-bank location. A linear address is a flat 12-bit index, with the bank in the top four bits and the register in the low eight. The transfer reads this address from a pair of working registers and ignores the pointer when it resolves it. The block also offers a combinational read port, which reports both the data and the translated physical address, and a synchronous write port.

Top module: `brf_top`

## Requirements
- R1: After a synchronous reset the pointer reads 00h and `xf_busy` is low; a write through `rp_we` loads `rp_wdata` into the pointer at the next clock edge.
- R2: A direct address (mode 0) below 10h resolves to physical address {pointer low nibble, address}, with the bank in bits 11:8.
- R3: A direct address of 10h or above resolves to bank 0 with the register number unchanged.
- R4: A working address (mode 1) n forms the 8-bit address {pointer high nibble, n}, and that address then follows R2 and R3.
- R5: The read port is combinational from the translated address. A write takes effect at the clock edge, so a read of the same location in the write cycle still returns the old value.
- R6: Pair index p selects working registers 2p (high) and 2p+1 (low). The low nibble of the high register gives linear bits 11:8, its high nibble is ignored, and the low register gives bits 7:0. With direction 0 the byte moves from the linear location to the current-bank direct address `xf_cur`. With direction 1 it moves the other way.
- R7: A transfer accepted at a clock edge keeps `xf_busy` high for exactly three cycles, and its destination is written at the edge where `xf_busy` falls.
- R8: While `xf_busy` is high, writes through the write port and writes to the pointer are ignored.
- R9: When a transfer's source and destination resolve to the same physical location, that location keeps the value it held before the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rp_we | input | 1 | Pointer write strobe |
| rp_wdata | input | 8 | New pointer value |
| rp_value | output | 8 | Current pointer value |
| rd_mode | input | 1 | Read address mode: 0 direct, 1 working |
| rd_addr | input | 8 | Read operand address |
| rd_data | output | DATA_W | Read data (combinational) |
| rd_phys | output | PHYS_W | Translated physical read address |
| wr_en | input | 1 | Write strobe |
| wr_mode | input | 1 | Write address mode: 0 direct, 1 working |
| wr_addr | input | 8 | Write operand address |
| wr_data | input | DATA_W | Write data |
| xf_start | input | 1 | Start a linear transfer |
| xf_dir | input | 1 | 0: linear to current bank, 1: current bank to linear |
| xf_pair | input | 3 | Working register pair index holding the linear address |
| xf_cur | input | 8 | Current-bank direct address of the other operand |
| xf_busy | output | 1 | Transfer in progress |

## Verification
The read port's data and translated address are due within the same cycle as the address. The bench drives the address on a falling edge and samples one nanosecond later. A write becomes visible only after the following rising edge, so the bench reads the old value before that edge and the new value at the next falling edge. A transfer raises `xf_busy` at its accepting edge and completes its write three edges later. The bench therefore checks `xf_busy` at the first falling edge after the start and reads the destination no earlier than the fourth.

// File: rtl/brf_pkg.sv
`timescale 1ns/1ps
package brf_pkg;
  // Register numbers inside one bank.
  localparam int REG_AW = 8;
  // Width of one pointer nibble (group or expanded bank).
  localparam int NIB_W = 4;
  // Number of direct addresses redirected to the expanded bank.
  localparam int XWIN = 16;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_HI   = 2'd1,
    XF_LO   = 2'd2,
    XF_MOVE = 2'd3
  } xf_state_t;
endpackage

// File: rtl/brf_ptr_reg.sv
`timescale 1ns/1ps
module brf_ptr_reg #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PTR_W-1:0] wdata,
  output logic [PTR_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)     value <= '0;
    else if (we) value <= wdata;
  end
endmodule

// File: rtl/brf_resolve.sv
`timescale 1ns/1ps
module brf_resolve
  import brf_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic [2*NIB_W-1:0]       ptr,
  input  logic                     wmode,
  input  logic [REG_AW-1:0]        addr,
  output logic [BANK_W+REG_AW-1:0] phys
);
  logic [REG_AW-1:0] eff;
  logic              in_window;

  always_comb begin
    // working address: prepend the group nibble
    eff = wmode ? {ptr[2*NIB_W-1:NIB_W], addr[NIB_W-1:0]} : addr;
    in_window = (eff < REG_AW'(XWIN));
    if (in_window) phys = {ptr[BANK_W-1:0], eff};
    else           phys = {{BANK_W{1'b0}}, eff};
  end
endmodule

// File: rtl/brf_store.sv
`timescale 1ns/1ps
module brf_store #(
  parameter int DATA_W = 8,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/brf_xfer.sv
`timescale 1ns/1ps
module brf_xfer
  import brf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     dir,
  input  logic [2:0]               pair,
  input  logic [REG_AW-1:0]        cur,
  input  logic [BANK_W+REG_AW-1:0] cur_phys,
  input  logic [BANK_W+REG_AW-1:0] pair_phys,
  input  logic [DATA_W-1:0]        rdata,
  output logic [REG_AW-1:0]        cur_q,
  output logic [NIB_W-1:0]         pair_reg,
  output logic [BANK_W+REG_AW-1:0] raddr,
  output logic                     busy,
  output logic                     we,
  output logic [BANK_W+REG_AW-1:0] waddr,
  output logic [DATA_W-1:0]        wdata
);
  localparam int PHYS_W = BANK_W + REG_AW;

  xf_state_t          st;
  logic               dir_q;
  logic [2:0]         pair_q;
  logic [BANK_W-1:0]  lin_hi;
  logic [REG_AW-1:0]  lin_lo;
  logic [PHYS_W-1:0]  lin;

  assign lin      = {lin_hi, lin_lo};
  assign busy     = (st != XF_IDLE);
  assign pair_reg = {pair_q, (st == XF_LO)};

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= XF_IDLE;
      dir_q  <= 1'b0;
      pair_q <= '0;
      cur_q  <= '0;
      lin_hi <= '0;
      lin_lo <= '0;
    end else begin
      unique case (st)
        XF_IDLE: if (start) begin
          dir_q  <= dir;
          pair_q <= pair;
          cur_q  <= cur;
          st     <= XF_HI;
        end
        XF_HI: begin
          lin_hi <= rdata[BANK_W-1:0];
          st     <= XF_LO;
        end
        XF_LO: begin
          lin_lo <= rdata[REG_AW-1:0];
          st     <= XF_MOVE;
        end
        XF_MOVE: st <= XF_IDLE;
        default: st <= XF_IDLE;
      endcase
    end
  end

  always_comb begin
    raddr = pair_phys;
    waddr = cur_phys;
    wdata = rdata;
    we    = 1'b0;
    if (st == XF_MOVE) begin
      raddr = dir_q ? cur_phys : lin;
      waddr = dir_q ? lin : cur_phys;
      we    = 1'b1;
    end
  end
endmodule

// File: rtl/brf_top.sv
`timescale 1ns/1ps
module brf_top
  import brf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int PHYS_W   = BANK_W + REG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rp_we,
  input  logic [7:0]        rp_wdata,
  output logic [7:0]        rp_value,
  input  logic              rd_mode,
  input  logic [7:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [PHYS_W-1:0] rd_phys,
  input  logic              wr_en,
  input  logic              wr_mode,
  input  logic [7:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xf_start,
  input  logic              xf_dir,
  input  logic [2:0]        xf_pair,
  input  logic [7:0]        xf_cur,
  output logic              xf_busy
);
  localparam int NRES = 4;  // read, write, transfer current, transfer pair

  logic              res_mode [NRES];
  logic [7:0]        res_addr [NRES];
  logic [PHYS_W-1:0] res_phys [NRES];

  logic [7:0]        xf_cur_q;
  logic [NIB_W-1:0]  xf_pair_reg;
  logic [PHYS_W-1:0] xf_raddr;
  logic              xf_we;
  logic [PHYS_W-1:0] xf_waddr;
  logic [DATA_W-1:0] xf_wdata;
  logic [DATA_W-1:0] int_rdata;

  logic              mem_we;
  logic [PHYS_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  brf_ptr_reg #(.PTR_W(8)) ptr_i (
    .clk   (clk),
    .rst   (rst),
    .we    (rp_we & ~xf_busy),
    .wdata (rp_wdata),
    .value (rp_value)
  );

  assign res_mode[0] = rd_mode;
  assign res_addr[0] = rd_addr;
  assign res_mode[1] = wr_mode;
  assign res_addr[1] = wr_addr;
  assign res_mode[2] = 1'b0;
  assign res_addr[2] = xf_cur_q;
  assign res_mode[3] = 1'b1;
  assign res_addr[3] = {{(8-NIB_W){1'b0}}, xf_pair_reg};

  for (genvar g = 0; g < NRES; g++) begin : g_res
    brf_resolve #(.BANK_W(BANK_W)) res_i (
      .ptr   (rp_value),
      .wmode (res_mode[g]),
      .addr  (res_addr[g]),
      .phys  (res_phys[g])
    );
  end

  brf_xfer #(.DATA_W(DATA_W), .BANK_W(BANK_W)) xfer_i (
    .clk       (clk),
    .rst       (rst),
    .start     (xf_start),
    .dir       (xf_dir),
    .pair      (xf_pair),
    .cur       (xf_cur),
    .cur_phys  (res_phys[2]),
    .pair_phys (res_phys[3]),
    .rdata     (int_rdata),
    .cur_q     (xf_cur_q),
    .pair_reg  (xf_pair_reg),
    .raddr     (xf_raddr),
    .busy      (xf_busy),
    .we        (xf_we),
    .waddr     (xf_waddr),
    .wdata     (xf_wdata)
  );

  always_comb begin
    if (xf_busy) begin
      mem_we    = xf_we;
      mem_waddr = xf_waddr;
      mem_wdata = xf_wdata;
    end else begin
      mem_we    = wr_en;
      mem_waddr = res_phys[1];
      mem_wdata = wr_data;
    end
  end

  brf_store #(.DATA_W(DATA_W), .AW(PHYS_W)) store_i (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr_a (res_phys[0]),
    .rdata_a (rd_data),
    .raddr_b (xf_raddr),
    .rdata_b (int_rdata)
  );

  assign rd_phys = res_phys[0];
endmodule

// File: rtl/brf_checker.sv
`timescale 1ns/1ps
module brf_checker #(
  parameter int BANK_W = 4,
  localparam int PHYS_W = BANK_W + 8
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        rp_value,
  input logic              rd_mode,
  input logic [7:0]        rd_addr,
  input logic [PHYS_W-1:0] rd_phys,
  input logic              xf_start,
  input logic              xf_busy
);
  logic [2:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !xf_busy) busy_cnt <= '0;
    else if (busy_cnt != 3'd7) busy_cnt <= busy_cnt + 3'd1;
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rp_value == 8'h00 && !xf_busy));

  a_r2_low_window: assert property (@(posedge clk) disable iff (rst)
    (!rd_mode && rd_addr < 8'h10) |-> rd_phys == {rp_value[BANK_W-1:0], rd_addr});

  a_r3_bank_zero: assert property (@(posedge clk) disable iff (rst)
    (!rd_mode && rd_addr >= 8'h10) |-> rd_phys == {{BANK_W{1'b0}}, rd_addr});

  a_r4_group_prefix: assert property (@(posedge clk) disable iff (rst)
    (rd_mode && rp_value[7:4] != 4'h0)
      |-> rd_phys == {{BANK_W{1'b0}}, rp_value[7:4], rd_addr[3:0]});

  a_r7_busy_enter: assert property (@(posedge clk) disable iff (rst)
    (xf_start && !xf_busy) |=> xf_busy);

  a_r7_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(xf_busy) |-> busy_cnt == 3'd3);

  a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
    xf_busy |=> $stable(rp_value));
endmodule

bind brf_top brf_checker #(.BANK_W(BANK_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .rp_value (rp_value),
  .rd_mode  (rd_mode),
  .rd_addr  (rd_addr),
  .rd_phys  (rd_phys),
  .xf_start (xf_start),
  .xf_busy  (xf_busy)
);

// File: tb/brf_top_tb.sv
`timescale 1ns/1ps
module brf_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rp_we = 1'b0;
  logic [7:0]  rp_wdata = '0;
  logic [7:0]  rp_value;
  logic        rd_mode = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [11:0] rd_phys;
  logic        wr_en = 1'b0;
  logic        wr_mode = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        xf_start = 1'b0;
  logic        xf_dir = 1'b0;
  logic [2:0]  xf_pair = '0;
  logic [7:0]  xf_cur = '0;
  logic        xf_busy;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  brf_top dut_i (
    .clk(clk), .rst(rst),
    .rp_we(rp_we), .rp_wdata(rp_wdata), .rp_value(rp_value),
    .rd_mode(rd_mode), .rd_addr(rd_addr), .rd_data(rd_data), .rd_phys(rd_phys),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr), .wr_data(wr_data),
    .xf_start(xf_start), .xf_dir(xf_dir), .xf_pair(xf_pair), .xf_cur(xf_cur),
    .xf_busy(xf_busy)
  );

  // {pointer, mode, address, expected physical address}
  localparam int NV = 14;
  localparam logic [28:0] VEC [NV] = '{
    {8'h00, 1'b1, 8'h00, 12'h000},
    {8'h00, 1'b1, 8'h04, 12'h004},
    {8'h0D, 1'b1, 8'h00, 12'hD00},
    {8'h0D, 1'b1, 8'h04, 12'hD04},
    {8'h7D, 1'b0, 8'h02, 12'hD02},
    {8'h7D, 1'b0, 8'h71, 12'h071},
    {8'h7D, 1'b1, 8'h01, 12'h071},
    {8'h7D, 1'b0, 8'h10, 12'h010},
    {8'h7D, 1'b0, 8'h0F, 12'hD0F},
    {8'h0D, 1'b0, 8'hFF, 12'h0FF},
    {8'h25, 1'b1, 8'h0F, 12'h02F},
    {8'h05, 1'b1, 8'h0A, 12'h50A},
    {8'hF3, 1'b0, 8'h00, 12'h300},
    {8'h3C, 1'b0, 8'hFD, 12'h0FD}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_ptr(input logic [7:0] v);
    @(negedge clk); rp_we = 1'b1; rp_wdata = v;
    @(negedge clk); rp_we = 1'b0;
  endtask

  task automatic write_reg(input logic m, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_mode = m; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic m, input logic [7:0] a,
                          input logic [7:0] exp);
    @(negedge clk); rd_mode = m; rd_addr = a;
    #1 check(tag, rd_data, exp);
  endtask

  task automatic run_xfer(input logic d, input logic [2:0] p, input logic [7:0] c);
    @(negedge clk); xf_start = 1'b1; xf_dir = d; xf_pair = p; xf_cur = c;
    @(negedge clk); xf_start = 1'b0;
    check("R7 busy after accept", xf_busy, 1'b1);
    repeat (3) @(negedge clk);
    check("R7 busy cleared after three cycles", xf_busy, 1'b0);
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 pointer after reset", rp_value, 8'h00);
    check("R1 busy after reset", xf_busy, 1'b0);
    set_ptr(8'h5A);
    check("R1 pointer write", rp_value, 8'h5A);

    // address resolution table: R2 / R3 / R4
    for (int i = 0; i < NV; i++) begin
      set_ptr(VEC[i][28:21]);
      @(negedge clk); rd_mode = VEC[i][20]; rd_addr = VEC[i][19:12];
      #1;
      if (VEC[i][20])                check("R4 working resolve", rd_phys, VEC[i][11:0]);
      else if (VEC[i][19:12] < 8'h10) check("R2 low window", rd_phys, VEC[i][11:0]);
      else                           check("R3 bank zero", rd_phys, VEC[i][11:0]);
    end

    // R5 synchronous write, combinational read
    set_ptr(8'h03);
    write_reg(1'b0, 8'h05, 8'h5C);
    read_chk("R5 readback bank 3", 1'b0, 8'h05, 8'h5C);
    write_reg(1'b0, 8'h40, 8'h11);
    @(negedge clk);
    wr_en = 1'b1; wr_mode = 1'b0; wr_addr = 8'h40; wr_data = 8'h3A;
    rd_mode = 1'b0; rd_addr = 8'h40;
    #1 check("R5 old value before edge", rd_data, 8'h11);
    @(negedge clk); wr_en = 1'b0;
    #1 check("R5 new value after edge", rd_data, 8'h3A);

    // R6 transfer linear -> current bank, high nibble of pair ignored
    set_ptr(8'h7D);
    write_reg(1'b0, 8'h70, 8'hA3);
    write_reg(1'b0, 8'h71, 8'h05);
    read_chk("R4 working R0 data", 1'b1, 8'h00, 8'hA3);
    run_xfer(1'b0, 3'd0, 8'h20);
    read_chk("R6 linear to current", 1'b0, 8'h20, 8'h5C);

    // R6 transfer current -> linear
    write_reg(1'b0, 8'h21, 8'h99);
    run_xfer(1'b1, 3'd0, 8'h21);
    set_ptr(8'h03);
    read_chk("R6 current to linear", 1'b0, 8'h05, 8'h99);

    // R8 writes ignored while busy
    set_ptr(8'h7D);
    write_reg(1'b0, 8'h30, 8'h11);
    @(negedge clk); xf_start = 1'b1; xf_dir = 1'b0; xf_pair = 3'd0; xf_cur = 8'h22;
    @(negedge clk); xf_start = 1'b0;
    wr_en = 1'b1; wr_mode = 1'b0; wr_addr = 8'h30; wr_data = 8'hEE;
    rp_we = 1'b1; rp_wdata = 8'hFF;
    @(negedge clk); wr_en = 1'b0; rp_we = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 pointer unchanged", rp_value, 8'h7D);
    read_chk("R8 write dropped", 1'b0, 8'h30, 8'h11);
    read_chk("R6 transfer during R8 test", 1'b0, 8'h22, 8'h99);

    // R9 same-location transfer, both directions
    write_reg(1'b0, 8'h72, 8'h00);
    write_reg(1'b0, 8'h73, 8'h25);
    write_reg(1'b0, 8'h25, 8'h6B);
    run_xfer(1'b0, 3'd1, 8'h25);
    read_chk("R9 same location dir 0", 1'b0, 8'h25, 8'h6B);
    run_xfer(1'b1, 3'd1, 8'h25);
    read_chk("R9 same location dir 1", 1'b0, 8'h25, 8'h6B);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule